// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplex Mode

This block is a small register. Each clock edge it can write a single data bit into one chosen position, selected by a binary address, and it shows every stored bit on a parallel output bus at all times. It suits places where a serial control source has to set individual enable or select lines one at a time without disturbing the other lines.

Two active-high controls pick the operation for the next rising edge. `holdReq` blocks writes. `clearReq` is a functional clear. Their four combinations give four modes: store the bit into one position, hold every bit, clear every bit, or act as a demultiplexer. In demultiplex mode the addressed output takes the data bit and every other output is forced to zero. A separate asynchronous active-low input clears the register at power-up.

Top module: `addr_bit_latch`

## Requirements
- R1: While `rstN` is low, `latchOut` is all zeros at once, without waiting for a clock edge.
- R2: With `holdReq`=0 and `clearReq`=0, the next rising edge stores `dataIn` into bit `addrSel` of `latchOut`. `addrSel` is an unsigned binary index with bit 0 as the least significant bit. The other bits keep their values.
- R3: With `holdReq`=1 and `clearReq`=0, the next rising edge changes no bit, whatever `addrSel` and `dataIn` are.
- R4: With `holdReq`=1 and `clearReq`=1, the next rising edge clears every bit of `latchOut` to 0.
- R5: With `holdReq`=0 and `clearReq`=1, the next rising edge sets bit `addrSel` to `dataIn` and sets every other bit to 0.
- R6: When hold mode follows demultiplex mode, the demultiplexed pattern is kept: the addressed bit keeps the last data value and all other bits stay 0.
- R7: In store mode, at most one bit of `latchOut` changes per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low power-on clear |
| dataIn | input | 1 | Data bit to store or route |
| addrSel | input | ADDR_W (3) | Index of the target bit |
| holdReq | input | 1 | Active-high write inhibit |
| clearReq | input | 1 | Active-high functional clear / demultiplex select |
| latchOut | output | WIDTH (8) | Parallel view of all stored bits |

## Verification
The assertions assume that `holdReq`, `clearReq`, `addrSel` and `dataIn` are settled, with no X or Z, at every rising edge while `rstN` is high. They also assume that `addrSel` never names a bit beyond WIDTH-1. The stimulus changes inputs only on falling edges and draws addresses only from 0 to WIDTH-1. It holds every control at a known level from time zero, including while `rstN` is low.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode code is {clearReq, holdReq}
  typedef enum logic [1:0] {
    MODE_STORE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } latchMode_e;

  // Strobes from control to datapath; all zero means hold
  typedef struct packed {
    logic storeOne;
    logic demuxOne;
    logic clearAll;
  } latchStrobe_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         holdReq,
  input  logic         clearReq,
  output latchStrobe_t strobe
);

  latchMode_e mode;

  always_comb begin
    mode = latchMode_e'({clearReq, holdReq});
    strobe = '0;
    unique case (mode)
      MODE_STORE: strobe.storeOne = 1'b1;
      MODE_DEMUX: strobe.demuxOne = 1'b1;
      MODE_CLEAR: strobe.clearAll = 1'b1;
      default:    strobe = '0;
    endcase
  end

  // R3: inhibit without clear must raise no strobe
  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && !clearReq) |-> (strobe == '0));

endmodule

// File: rtl/addr_latch_dp.sv
module addr_latch_dp
  import addr_latch_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addrSel,
  input  latchStrobe_t      strobe,
  output logic [WIDTH-1:0]  bits
);

  logic [WIDTH-1:0] nextBits;

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    logic hit;
    assign hit = (addrSel == ADDR_W'(i));
    always_comb begin
      if (strobe.clearAll)      nextBits[i] = 1'b0;
      else if (strobe.demuxOne) nextBits[i] = hit & dataIn;
      else if (strobe.storeOne) nextBits[i] = hit ? dataIn : bits[i];
      else                      nextBits[i] = bits[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bits <= '0;
    else       bits <= nextBits;
  end

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (bits == '0));

  assert_demux_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.demuxOne |=> $onehot0(bits));

  assert_demux_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.demuxOne |=> (bits[$past(addrSel)] == $past(dataIn)));

  assert_store_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeOne |=> ($countones(bits ^ $past(bits)) <= 1));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(bits));

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import addr_latch_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addrSel,
  input  logic              holdReq,
  input  logic              clearReq,
  output logic [WIDTH-1:0]  latchOut
);

  latchStrobe_t strobe;

  addr_latch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .holdReq  (holdReq),
    .clearReq (clearReq),
    .strobe   (strobe)
  );

  addr_latch_dp #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .addrSel (addrSel),
    .strobe  (strobe),
    .bits    (latchOut)
  );

endmodule

// File: tb/tb_addr_bit_latch.sv
module tb_addr_bit_latch;

  localparam int WIDTH  = 8;
  localparam int ADDR_W = 3;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dataIn = 1'b0;
  logic [ADDR_W-1:0] addrSel = '0;
  logic              holdReq = 1'b1;
  logic              clearReq = 1'b0;
  logic [WIDTH-1:0]  latchOut;

  addr_bit_latch #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .addrSel(addrSel),
    .holdReq(holdReq), .clearReq(clearReq), .latchOut(latchOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [WIDTH-1:0] expVal;
    string            reqTag;
  } expItem_t;

  expItem_t         scoreQ[$];
  logic [WIDTH-1:0] model = '0;
  logic             lastDemux = 1'b0;
  int               numChecks = 0;
  int               numFails = 0;

  task automatic checkNow(input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp,
                          input string tag);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: latchOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: set inputs at a falling edge and queue what the next edge must produce
  task automatic applyOp(input logic inh, input logic clr,
                         input logic [ADDR_W-1:0] a, input logic d);
    expItem_t it;
    @(negedge clk);
    holdReq = inh; clearReq = clr; addrSel = a; dataIn = d;
    unique case ({clr, inh})
      2'b00: begin model[a] = d; it.reqTag = "R2/R7"; lastDemux = 1'b0; end
      2'b01: begin it.reqTag = lastDemux ? "R6" : "R3"; end
      2'b10: begin model = '0; model[a] = d; it.reqTag = "R5"; lastDemux = 1'b1; end
      default: begin model = '0; it.reqTag = "R4"; lastDemux = 1'b0; end
    endcase
    it.expVal = model;
    scoreQ.push_back(it);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        checkNow(latchOut, it.expVal, it.reqTag);
      end
    end
  end

  task automatic drainQueue();
    while (scoreQ.size() > 0) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    numFails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finishRun();
  end

  initial begin
    #2;
    checkNow(latchOut, '0, "R1");
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R2: walk every address with ones, then clear odd bits
    for (int i = 0; i < WIDTH; i++) applyOp(1'b0, 1'b0, ADDR_W'(i), 1'b1);
    for (int i = 1; i < WIDTH; i += 2) applyOp(1'b0, 1'b0, ADDR_W'(i), 1'b0);
    // R3: inhibit with changing address and data
    for (int i = 0; i < WIDTH; i++) applyOp(1'b1, 1'b0, ADDR_W'(i), i[0]);
    // R5: demux walk, then R6 hold afterwards
    for (int i = 0; i < WIDTH; i++) applyOp(1'b0, 1'b1, ADDR_W'(i), 1'b1);
    applyOp(1'b1, 1'b0, 3'd0, 1'b0);
    applyOp(1'b1, 1'b0, 3'd5, 1'b1);
    applyOp(1'b0, 1'b1, 3'd2, 1'b0);
    applyOp(1'b1, 1'b0, 3'd2, 1'b1);
    // R4: fill then clear
    for (int i = 0; i < WIDTH; i++) applyOp(1'b0, 1'b0, ADDR_W'(i), 1'b1);
    applyOp(1'b1, 1'b1, 3'd4, 1'b1);
    applyOp(1'b1, 1'b0, 3'd4, 1'b1);

    // R1: asynchronous clear in mid run
    applyOp(1'b0, 1'b0, 3'd6, 1'b1);
    applyOp(1'b0, 1'b0, 3'd1, 1'b1);
    drainQueue();
    @(negedge clk);
    holdReq = 1'b1; clearReq = 1'b0;
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    checkNow(latchOut, '0, "R1");
    model = '0; lastDemux = 1'b0;
    @(negedge clk);
    checkNow(latchOut, '0, "R1");
    rstN = 1'b1;

    // Random mix of all four modes
    for (int n = 0; n < 3000; n++) begin
      applyOp(1'($urandom), 1'($urandom_range(0, 3) == 0),
              ADDR_W'($urandom_range(0, WIDTH-1)), 1'($urandom));
    end
    drainQueue();
    @(negedge clk);
    finishRun();
  end

endmodule